// File: doc/BRIEF.md
# Dual Masked CAN Acceptance Filter

This block decides whether a received CAN frame should be kept. The frame receiver passes it the header of each frame: the 11-bit identifier, the remote-request bit and the format bit. It passes them together with a one-cycle strobe. The block forms a 12-bit key from the identifier and the remote-request bit. It then tests that key against two programmable filters. Each filter has a compare value and a don't-care mask.

The result is registered on the clock edge that samples the strobe. It then stays unchanged until the next strobe, so buffer-storage logic can read it at leisure. The result has two parts: an accept flag and the index of the winning filter. Extended-format frames are never accepted. Acknowledgement of frames is generated elsewhere and does not depend on this block.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, `accept_o` is 0 and `match_idx_o` is 0.
- R2: The 12-bit key is the identifier in key bits 11..1 and the remote-request bit in key bit 0. A key bit whose don't-care bit is 1 matches whatever its value.
- R3: A key bit whose don't-care bit is 0 matches only when it equals the compare bit at the same position. A filter matches when all 12 of its key bits match.
- R4: A standard frame is accepted (`accept_o`=1) when at least one filter matches.
- R5: The lowest-numbered matching filter is reported on `match_idx_o`. When both filters match, filter 0 is reported.
- R6: A frame whose format bit `hdr_ext_i` is 1 gives `accept_o`=0, even when a filter matches.
- R7: When no filter matches, `accept_o` is 0 and `match_idx_o` is 0.
- R8: The outputs change exactly one clock after the cycle in which `hdr_valid_i` is 1. They hold their values while `hdr_valid_i` is 0, even when the header or filter inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_valid_i | input | 1 | One-cycle strobe: the header fields are valid |
| hdr_id_i | input | 11 | Received identifier |
| hdr_rtr_i | input | 1 | Remote-request bit |
| hdr_ext_i | input | 1 | 1 = extended-format frame |
| flt_cmp_i | input | 24 | Compare values; filter k occupies bits [12k+11:12k] |
| flt_dc_i | input | 24 | Don't-care masks; filter k occupies bits [12k+11:12k], 1 = ignore |
| accept_o | output | 1 | Frame accepted for storage |
| match_idx_o | output | 1 | Index of the reporting filter |

## Verification
A wrong registered decision shows on `accept_o` or `match_idx_o` one clock after the strobe. Because the value is held, it stays visible until the next strobe. Some faults only disturb the held value between strobes, such as a capture enable that ignores the strobe. These faults show up in the first idle cycle after the header or filter inputs change. Faults in key ordering or in mask polarity show only for patterns that put a difference in a specific bit. The tests therefore put such differences in the remote-request bit, in the highest identifier bit, and in bits that are masked.

// File: rtl/can_af_pkg.sv
package can_af_pkg;
    localparam int unsigned ID_W  = 11;
    localparam int unsigned KEY_W = ID_W + 1;

    typedef logic [KEY_W-1:0] af_key_t;

    function automatic af_key_t make_key(input logic [ID_W-1:0] id, input logic rtr);
        return {id, rtr};
    endfunction
endpackage

// File: rtl/can_af_match.sv
module can_af_match #(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] key_i,
    input  logic [W-1:0] cmp_i,
    input  logic [W-1:0] dc_i,
    output logic         hit_o
);
    logic [W-1:0] bit_ok;

    always_comb begin
        bit_ok = dc_i | ~(key_i ^ cmp_i);
        hit_o  = &bit_ok;
    end
endmodule

// File: rtl/can_af_prio.sv
module can_af_prio #(
    parameter int unsigned N     = 2,
    parameter int unsigned IDX_W = 1
) (
    input  logic [N-1:0]     hit_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = |hit_i;
        idx_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (hit_i[k]) begin
                idx_o = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_af_pkg::*;
#(
    parameter int unsigned NUM_FILT = 2,
    localparam int unsigned IDX_W   = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1,
    localparam int unsigned CFG_W   = NUM_FILT * KEY_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hdr_valid_i,
    input  logic [ID_W-1:0]  hdr_id_i,
    input  logic             hdr_rtr_i,
    input  logic             hdr_ext_i,
    input  logic [CFG_W-1:0] flt_cmp_i,
    input  logic [CFG_W-1:0] flt_dc_i,
    output logic             accept_o,
    output logic [IDX_W-1:0] match_idx_o
);
    typedef struct packed {
        logic             accept;
        logic [IDX_W-1:0] idx;
    } af_state_t;

    af_state_t        st_d, st_q;
    af_key_t          rx_key;
    logic [NUM_FILT-1:0] hit;
    logic             any_hit;
    logic [IDX_W-1:0] win_idx;

    assign rx_key = make_key(hdr_id_i, hdr_rtr_i);

    for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
        can_af_match #(.W(KEY_W)) u_match (
            .key_i (rx_key),
            .cmp_i (flt_cmp_i[g*KEY_W +: KEY_W]),
            .dc_i  (flt_dc_i[g*KEY_W +: KEY_W]),
            .hit_o (hit[g])
        );
    end

    can_af_prio #(.N(NUM_FILT), .IDX_W(IDX_W)) u_prio (
        .hit_i (hit),
        .any_o (any_hit),
        .idx_o (win_idx)
    );

    always_comb begin
        st_d = st_q;
        if (hdr_valid_i) begin
            st_d.accept = any_hit && !hdr_ext_i;
            st_d.idx    = st_d.accept ? win_idx : '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept_o    = st_q.accept;
    assign match_idx_o = st_q.idx;
endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk
    import can_af_pkg::*;
#(
    parameter int unsigned IDX_W = 1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             hdr_valid_i,
    input logic [ID_W-1:0]  hdr_id_i,
    input logic             hdr_rtr_i,
    input logic             hdr_ext_i,
    input logic [KEY_W-1:0] cmp0_i,
    input logic [KEY_W-1:0] dc0_i,
    input logic             accept_o,
    input logic [IDX_W-1:0] match_idx_o
);
    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hdr_valid_i |=> ($stable(accept_o) && $stable(match_idx_o))); // R8

    AST_EXT_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hdr_valid_i && hdr_ext_i) |=> !accept_o); // R6

    AST_REJECT_IDX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !accept_o |-> (match_idx_o == '0)); // R7

    AST_ALL_DC_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hdr_valid_i && !hdr_ext_i && (dc0_i == '1)) |=> (accept_o && match_idx_o == '0)); // R5

    AST_EXACT_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hdr_valid_i && !hdr_ext_i && (dc0_i == '0) && ({hdr_id_i, hdr_rtr_i} == cmp0_i))
        |=> (accept_o && match_idx_o == '0)); // R3
endmodule

bind can_accept_filter can_accept_filter_chk #(.IDX_W(IDX_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hdr_valid_i (hdr_valid_i),
    .hdr_id_i    (hdr_id_i),
    .hdr_rtr_i   (hdr_rtr_i),
    .hdr_ext_i   (hdr_ext_i),
    .cmp0_i      (flt_cmp_i[KEY_W-1:0]),
    .dc0_i       (flt_dc_i[KEY_W-1:0]),
    .accept_o    (accept_o),
    .match_idx_o (match_idx_o)
);

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        hdr_valid_i = 1'b0;
    logic [10:0] hdr_id_i = '0;
    logic        hdr_rtr_i = 1'b0;
    logic        hdr_ext_i = 1'b0;
    logic [23:0] flt_cmp_i = '0;
    logic [23:0] flt_dc_i = '0;
    logic        accept_o;
    logic [0:0]  match_idx_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk_i = ~clk_i;

    can_accept_filter dut_i (
        .clk_i, .rst_ni, .hdr_valid_i, .hdr_id_i, .hdr_rtr_i, .hdr_ext_i,
        .flt_cmp_i, .flt_dc_i, .accept_o, .match_idx_o
    );

    task automatic check(input string req, input logic acc, input logic idx);
        n_chk++;
        if (accept_o !== acc || match_idx_o !== idx) begin
            n_fail++;
            $display("FAIL %s: accept=%b idx=%0d expected accept=%b idx=%0d",
                     req, accept_o, match_idx_o, acc, idx);
        end
    endtask

    task automatic set_filt(input logic [11:0] c0, input logic [11:0] d0,
                            input logic [11:0] c1, input logic [11:0] d1);
        @(negedge clk_i);
        flt_cmp_i = {c1, c0};
        flt_dc_i  = {d1, d0};
    endtask

    // strobe one header, then sample at the following negedge (one register)
    task automatic send(input logic [10:0] id, input logic rtr, input logic ext);
        @(negedge clk_i);
        hdr_id_i = id; hdr_rtr_i = rtr; hdr_ext_i = ext; hdr_valid_i = 1'b1;
        @(negedge clk_i);
        hdr_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset", 1'b0, 1'b0);
    endtask

    task automatic t_exact();
        set_filt(12'hA5C, 12'h000, 12'hFFF, 12'h000);
        send(11'h52E, 1'b0, 1'b0);             // key = {52E,0} = A5C
        check("R3 exact match f0", 1'b1, 1'b0);
        send(11'h52E, 1'b1, 1'b0);             // RTR bit differs (key bit 0)
        check("R2 rtr is key bit0", 1'b0, 1'b0);
        send(11'h12E, 1'b0, 1'b0);             // top id bit differs
        check("R3 msb mismatch", 1'b0, 1'b0);
    endtask

    task automatic t_mask();
        set_filt(12'hA5C, 12'h801, 12'hFFF, 12'h000);
        send(11'h12E, 1'b1, 1'b0);             // differs only in masked bits 11 and 0
        check("R2 masked bits ignored", 1'b1, 1'b0);
        send(11'h12F, 1'b1, 1'b0);             // bit 1 differs, not masked
        check("R3 unmasked bit mismatch", 1'b0, 1'b0);
    endtask

    task automatic t_second();
        set_filt(12'h000, 12'h000, 12'h246, 12'h000);
        send(11'h123, 1'b0, 1'b0);             // key 246 hits f1 only
        check("R4 filter1 only", 1'b1, 1'b1);
        send(11'h000, 1'b0, 1'b0);             // key 000 hits f0 only
        check("R4 filter0 only", 1'b1, 1'b0);
    endtask

    task automatic t_both();
        set_filt(12'h246, 12'h000, 12'h240, 12'h00F);
        send(11'h123, 1'b0, 1'b0);
        check("R5 both match -> 0", 1'b1, 1'b0);
        send(11'h120, 1'b1, 1'b0);             // key 241: f1 only
        check("R5 lower-only f1", 1'b1, 1'b1);
    endtask

    task automatic t_ext();
        set_filt(12'h000, 12'hFFF, 12'h000, 12'hFFF);
        send(11'h7FF, 1'b1, 1'b1);
        check("R6 extended rejected", 1'b0, 1'b0);
    endtask

    task automatic t_nomatch();
        set_filt(12'h000, 12'h000, 12'h246, 12'h000);
        send(11'h123, 1'b0, 1'b0);
        check("R7 setup accept f1", 1'b1, 1'b1);
        send(11'h555, 1'b0, 1'b0);
        check("R7 no match idx 0", 1'b0, 1'b0);
    endtask

    task automatic t_hold();
        set_filt(12'h000, 12'h000, 12'h246, 12'h000);
        send(11'h123, 1'b0, 1'b0);
        check("R8 accept after strobe", 1'b1, 1'b1);
        @(negedge clk_i);
        hdr_id_i = 11'h555; flt_cmp_i = '0; flt_dc_i = '0;
        @(negedge clk_i);
        check("R8 hold on input change", 1'b1, 1'b1);
        repeat (3) @(negedge clk_i);
        check("R8 hold idle", 1'b1, 1'b1);
        // latency: not yet updated on the strobe cycle itself
        hdr_id_i = 11'h555; hdr_valid_i = 1'b1;
        #1;
        check("R8 no change before edge", 1'b1, 1'b1);
        @(negedge clk_i);
        hdr_valid_i = 1'b0;
        check("R8 update one clock later", 1'b0, 1'b0);
    endtask

    initial begin
        repeat (2) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        t_exact();
        t_mask();
        t_second();
        t_both();
        t_ext();
        t_nomatch();
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk_i);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule